// File: doc/BRIEF.md
# Processor Debug Halt Controller

This block decides the exact point at which a simple in-order CPU core stops and enters debug mode. It watches a small set of pipeline events: core reset, an instruction entering the instruction latch, an instruction completing, an instruction being aborted, and the core sitting in a low-power state. It combines these events with three halt sources. The first is a debug-request bit set through a small register port. The second is a breakpoint instruction that only halts when a force-debug enable is set. The third is an instruction trace counter.

Each source has its own halt point. A request pending through core reset lets the core fetch the reset vector and the first handler instruction, then halts before anything executes. A request made while the core runs halts the core once the next fetched instruction is in the latch. A request made while the core sleeps first raises a wake request. A breakpoint halts the core once the instruction after it has been fetched. The trace counter halts the core when an instruction completes while the count is already zero.

Once `halt` is raised it stays high, and the trace count stays frozen, until a single-cycle release pulse arrives. That pulse also clears the request bit. All pins are plain control and status signals. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After `rst_n` is deasserted, `halt` is 0, `wake_req` is 0, `halt_cause` is 0 and `trace_count` is 0.
- R2: A control write (`cfg_sel`=0, `cfg_wdata` bit 0 = 1) sets the debug-request bit while the core runs. `halt` stays low through completing instructions and rises in the cycle after the next `fetch_latch` pulse, with `halt_cause` = 1.
- R3: Suppose the request bit is set while `core_rst` is high and `core_rst` then falls. `exec_done` has no effect, the first `fetch_latch` does not halt, and `halt` rises in the cycle after the second `fetch_latch`, with `halt_cause` = 0.
- R4: While `lowpwr` is high and the request bit is set, `wake_req` is 1. The next `fetch_latch` halts the core with `halt_cause` = 1, and `wake_req` drops while halted.
- R5: Force-debug enable is control bit 1. When it is set, an `exec_done` with `exec_bkpt` makes `halt` rise in the cycle after the next `fetch_latch`, with `halt_cause` = 2. When it is clear, a breakpoint does not halt the core.
- R6: Trace enable is control bit 2. When it is set, each `exec_done` without `exec_abort` decrements a nonzero `trace_count` by one. An `exec_done` with `exec_abort` changes nothing. An executed instruction at count 0 raises `halt` in the next cycle, with `halt_cause` = 3.
- R7: `halt` stays high until a `dbg_release` pulse and falls in the cycle after it. While `halt` is high, `trace_count` does not move. Release clears the request bit, so a later fetch does not halt the core.
- R8: A trace-count write (`cfg_sel`=1) loads `cfg_wdata` only while halted. The same write while running leaves `trace_count` unchanged.
- R9: When several causes fire in the same cycle, `halt_cause` reports the winner. The order is reset path (0), then request (1), then breakpoint (2), then trace (3). Any halt discards a pending breakpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of this block |
| core_rst | input | 1 | Core held in reset |
| lowpwr | input | 1 | Core in stop, doze or wait state |
| fetch_latch | input | 1 | An instruction entered the instruction latch |
| exec_done | input | 1 | An instruction completed or was aborted this cycle |
| exec_abort | input | 1 | The completing instruction was aborted |
| exec_bkpt | input | 1 | The completing instruction is a breakpoint |
| dbg_release | input | 1 | Single-cycle pulse leaving debug mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control (bit0 request, bit1 force-debug, bit2 trace enable), 1 = trace count |
| cfg_wdata | input | TRACE_W | Write data |
| halt | output | 1 | Core halted in debug mode |
| wake_req | output | 1 | Ask the core to leave its low-power state |
| halt_cause | output | 2 | Winning cause of the current halt |
| trace_count | output | TRACE_W | Current trace count |

## Verification
The bench uses the default parameters: an 8-bit trace count and a two-fetch reset path. Under these values a directed sequence reaches the count-zero boundary within a few instructions. The second fetch of the reset path is the exact cycle on which the reset halt must fire. The random phase loads small counts (0 to 5) so that most runs reach a trace halt, and it mixes aborted and executed completions against a bench model of the counter.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {
    CAUSE_RST   = 2'd0,
    CAUSE_EXT   = 2'd1,
    CAUSE_BKPT  = 2'd2,
    CAUSE_TRACE = 2'd3
  } cause_e;

  localparam int NUM_CAUSES = 4;
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_CNT  = 1'b1;
  localparam int CTRL_REQ   = 0;
  localparam int CTRL_FDB   = 1;
  localparam int CTRL_TREN  = 2;
endpackage

// File: rtl/dbg_cause_arb.sv
module dbg_cause_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/dbg_trace_ctr.sv
module dbg_trace_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (step && cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_pkg::*;
#(
  parameter int TRACE_W     = 8,
  parameter int RST_FETCHES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_rst,
  input  logic               lowpwr,
  input  logic               fetch_latch,
  input  logic               exec_done,
  input  logic               exec_abort,
  input  logic               exec_bkpt,
  input  logic               dbg_release,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [TRACE_W-1:0] cfg_wdata,
  output logic               halt,
  output logic               wake_req,
  output logic [1:0]         halt_cause,
  output logic [TRACE_W-1:0] trace_count
);
  localparam int RFW = $clog2(RST_FETCHES + 1);

  logic           halt_q, req_q, fdb_q, tren_q, bkpt_pend_q, rst_pend_q;
  logic [RFW-1:0] rfetch_q;
  logic [1:0]     cause_q;

  logic running, executed, tr_zero, ctrl_wr, cnt_wr;
  logic fire_rst, fire_ext, fire_bkpt, fire_trace, fire_any;
  logic [NUM_CAUSES-1:0] fire_vec;
  logic [1:0] fire_idx;

  assign running  = !halt_q && !core_rst;
  assign ctrl_wr  = cfg_we && (cfg_sel == SEL_CTRL);
  assign cnt_wr   = cfg_we && (cfg_sel == SEL_CNT) && halt_q;
  assign executed = running && !rst_pend_q && exec_done && !exec_abort;

  assign fire_rst   = running && rst_pend_q && fetch_latch &&
                      (rfetch_q == RFW'(RST_FETCHES - 1));
  assign fire_ext   = running && !rst_pend_q && req_q && fetch_latch;
  assign fire_bkpt  = running && !rst_pend_q && bkpt_pend_q && fetch_latch;
  assign fire_trace = executed && tren_q && tr_zero;

  always_comb begin
    fire_vec = '0;
    fire_vec[CAUSE_RST]   = fire_rst;
    fire_vec[CAUSE_EXT]   = fire_ext;
    fire_vec[CAUSE_BKPT]  = fire_bkpt;
    fire_vec[CAUSE_TRACE] = fire_trace;
  end

  dbg_cause_arb #(.N(NUM_CAUSES)) u_arb (
    .req (fire_vec),
    .any (fire_any),
    .idx (fire_idx)
  );

  dbg_trace_ctr #(.W(TRACE_W)) u_trace (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_wr),
    .load_val (cfg_wdata),
    .step     (executed && tren_q),
    .cnt      (trace_count),
    .zero     (tr_zero)
  );

  // halt flag and winning cause
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q  <= 1'b0;
      cause_q <= CAUSE_RST;
    end else if (halt_q) begin
      if (dbg_release) halt_q <= 1'b0;
    end else if (fire_any) begin
      halt_q  <= 1'b1;
      cause_q <= fire_idx;
    end
  end

  // control bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      fdb_q  <= 1'b0;
      tren_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        fdb_q  <= cfg_wdata[CTRL_FDB];
        tren_q <= cfg_wdata[CTRL_TREN];
      end
      if (halt_q && dbg_release)                req_q <= 1'b0;
      else if (ctrl_wr && cfg_wdata[CTRL_REQ])  req_q <= 1'b1;
    end
  end

  // breakpoint waits for the following fetch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                bkpt_pend_q <= 1'b0;
    else if (fire_any || dbg_release)          bkpt_pend_q <= 1'b0;
    else if (executed && exec_bkpt && fdb_q)   bkpt_pend_q <= 1'b1;
  end

  // reset path: request seen during core reset halts after N fetches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend_q <= 1'b0;
      rfetch_q   <= '0;
    end else if (core_rst) begin
      rst_pend_q <= req_q;
      rfetch_q   <= '0;
    end else if (fire_rst || (halt_q && dbg_release)) begin
      rst_pend_q <= 1'b0;
      rfetch_q   <= '0;
    end else if (running && rst_pend_q && fetch_latch) begin
      rfetch_q   <= rfetch_q + RFW'(1);
    end
  end

  assign halt       = halt_q;
  assign halt_cause = cause_q;
  assign wake_req   = lowpwr && req_q && !halt_q && !core_rst;
endmodule

// File: rtl/dbg_halt_chk.sv
module dbg_halt_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         halt,
  input logic         wake_req,
  input logic         dbg_release,
  input logic         cfg_we,
  input logic         cfg_sel,
  input logic         fetch_latch,
  input logic         exec_done,
  input logic [W-1:0] trace_count
);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !dbg_release |=> halt);

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    halt && dbg_release |=> !halt);

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !(cfg_we && cfg_sel) |=> $stable(trace_count));

  a_r2_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    !halt && !fetch_latch && !exec_done |=> !halt);

  a_r4_no_wake_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !wake_req);

  a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |=> (W'($past(trace_count) - trace_count) <= W'(1)));
endmodule

bind dbg_halt_ctrl dbg_halt_chk #(.W(TRACE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .halt        (halt),
  .wake_req    (wake_req),
  .dbg_release (dbg_release),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .fetch_latch (fetch_latch),
  .exec_done   (exec_done),
  .trace_count (trace_count)
);

// File: tb/tb_dbg_halt_ctrl.sv
module tb_dbg_halt_ctrl;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic core_rst = 0, lowpwr = 0, fetch_latch = 0, exec_done = 0;
  logic exec_abort = 0, exec_bkpt = 0, dbg_release = 0, cfg_we = 0, cfg_sel = 0;
  logic [W-1:0] cfg_wdata = '0;
  logic halt, wake_req;
  logic [1:0] halt_cause;
  logic [W-1:0] trace_count;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dbg_halt_ctrl dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(logic f, logic e, logic a, logic b);
    fetch_latch = f; exec_done = e; exec_abort = a; exec_bkpt = b;
    @(posedge clk); @(negedge clk);
    fetch_latch = 0; exec_done = 0; exec_abort = 0; exec_bkpt = 0;
    cfg_we = 0; dbg_release = 0;
  endtask

  task automatic wr(logic sel, logic [W-1:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    tick(0, 0, 0, 0);
  endtask

  task automatic rel();
    dbg_release = 1;
    tick(0, 0, 0, 0);
  endtask

  function automatic int dec_model(int c);
    return (c == 0) ? 0 : c - 1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 halt", halt, 0);
    chk("R1 wake", wake_req, 0);
    chk("R1 cause", halt_cause, 0);
    chk("R1 count", trace_count, 0);

    // R8 count write ignored while running
    wr(1, 8'd5);
    chk("R8 no load running", trace_count, 0);

    // R2 request during normal run
    wr(0, 8'h01);
    tick(0, 1, 0, 0);
    chk("R2 no halt before fetch", halt, 0);
    tick(1, 0, 0, 0);
    chk("R2 halt", halt, 1);
    chk("R2 cause", halt_cause, 1);
    // R7 hold
    tick(0, 0, 0, 0); tick(0, 0, 0, 0);
    chk("R7 held", halt, 1);
    // R8 load while halted, R7 frozen
    wr(1, 8'd3);
    chk("R8 load halted", trace_count, 3);
    tick(0, 1, 0, 0);
    chk("R7 frozen count", trace_count, 3);
    rel();
    chk("R7 released", halt, 0);
    tick(1, 0, 0, 0);
    chk("R7 request cleared", halt, 0);

    // R6 trace
    wr(0, 8'h04);
    for (int i = 2; i >= 0; i--) begin
      tick(0, 1, 0, 0);
      chk("R6 decrement", trace_count, i);
      chk("R6 no early halt", halt, 0);
    end
    tick(0, 1, 1, 0);
    chk("R6 abort no halt", halt, 0);
    chk("R6 abort count", trace_count, 0);
    tick(0, 1, 0, 0);
    chk("R6 trace halt", halt, 1);
    chk("R6 cause", halt_cause, 3);
    rel();

    // R5 breakpoint without enable
    wr(0, 8'h00);
    tick(0, 1, 0, 1);
    tick(1, 0, 0, 0);
    chk("R5 bkpt disabled", halt, 0);
    // R5 with enable
    wr(0, 8'h02);
    tick(0, 1, 0, 1);
    chk("R5 wait for fetch", halt, 0);
    tick(1, 0, 0, 0);
    chk("R5 bkpt halt", halt, 1);
    chk("R5 cause", halt_cause, 2);
    rel();

    // R9 request beats breakpoint
    tick(0, 1, 0, 1);
    wr(0, 8'h03);
    tick(1, 0, 0, 0);
    chk("R9 halt", halt, 1);
    chk("R9 cause ext", halt_cause, 1);
    rel();
    tick(1, 0, 0, 0);
    chk("R9 bkpt discarded", halt, 0);

    // R4 low-power wakeup
    wr(0, 8'h00);
    lowpwr = 1;
    wr(0, 8'h01);
    chk("R4 wake", wake_req, 1);
    chk("R4 no halt yet", halt, 0);
    lowpwr = 0;
    tick(1, 0, 0, 0);
    chk("R4 halt", halt, 1);
    lowpwr = 1;
    tick(0, 0, 0, 0);
    chk("R4 wake off halted", wake_req, 0);
    lowpwr = 0;
    rel();

    // R3 reset path
    core_rst = 1;
    wr(0, 8'h01);
    tick(0, 0, 0, 0); tick(0, 0, 0, 0);
    core_rst = 0;
    tick(1, 1, 0, 0);
    chk("R3 first fetch", halt, 0);
    tick(0, 1, 0, 0);
    chk("R3 exec ignored", halt, 0);
    tick(1, 0, 0, 0);
    chk("R3 halt", halt, 1);
    chk("R3 cause", halt_cause, 0);
    rel();

    // R6 random trace runs against a model
    wr(0, 8'h01);
    tick(1, 0, 0, 0);
    for (int r = 0; r < 20; r++) begin
      int mc;
      bit mh;
      mc = int'($urandom % 6);
      mh = 0;
      wr(1, W'(mc));
      wr(0, 8'h04);
      rel();
      for (int c = 0; c < 40 && !mh; c++) begin
        logic e, a;
        e = 1'($urandom % 2);
        a = 1'(($urandom % 4) == 0);
        if (e && !a) begin
          if (mc == 0) mh = 1; else mc = dec_model(mc);
        end
        tick(0, e, a, 0);
        chk("R6 random count", trace_count, mc);
        chk("R6 random halt", halt, mh);
      end
      if (mh) chk("R6 random cause", halt_cause, 3);
      else begin
        wr(0, 8'h05);
        tick(1, 0, 0, 0);
        chk("R2 forced halt", halt, 1);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule